// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by walking a two-level table held in memory. A client presents a virtual address, a read/write flag and the directory base of the address space that is active. The walker then reads one or two 32-bit table entries through a single-outstanding memory read port. It returns either a physical address with the three attribute bits of the final entry, or a fault.

Virtual address bits 31:22 select one of 1024 directory slots. Bits 21:12 select one of 1024 slots in a second-level table. Bits 11:0 are the byte offset within a 4 KB page. Every entry carries the same fields:

- bit 31: readable
- bit 30: writable
- bit 29: nonsecure
- bits 19:0: frame number

A table base address is the frame number shifted left by 12. In a directory entry, bit 28 set means the entry points to a second-level table. When bit 28 is clear, the entry maps a 4 MB section directly. The directory base input uses the same layout: attributes in bits 31:29 and the directory frame in bits 19:0. A base of all zeros marks the address space as disabled.

Top module: `iova_table_walker`

## Requirements
- R1: After a request is accepted with a nonzero base, the first memory read address is (base[19:0] << 12) + 4 × va[31:22].
- R2: If the directory entry has bit 28 set and grants the access, a second read is issued at (dir[19:0] << 12) + 4 × va[21:12]. The result is then pa = {pte[19:0], va[11:0]} with attr = pte[31:29].
- R3: If the directory entry has bit 28 clear and grants the access, no second read is issued. The result is then pa = {dir[19:10], va[21:0]} with attr = dir[31:29].
- R4: A read request that meets an entry with bit 31 clear ends the walk at that level with the fault flag set, pa = 0 and attr equal to that entry's bits 31:29. A fault at the directory level issues no table read.
- R5: A write request (write flag = 1) that meets an entry with bit 30 clear faults in the same way as R4, even when bit 31 is set.
- R6: A request whose base is all zeros issues no memory read. It completes with fault = 1, pa = 0 and attr = 0 one cycle after acceptance.
- R7: Vacant entries translate to the identity address. A vacant directory entry is (index << 10) | 0xE0000000. A vacant table entry is (va >> 12) | 0xE0000000.
- R8: At most one memory read is outstanding at a time. The read request and its address hold steady until accepted. New client requests are accepted only while idle.
- R9: After reset, the request-ready output is 1, and both the memory request valid and the result valid outputs are 0.
- R10: The result valid output is a single-cycle pulse. The attr output is ordered {readable, writable, nonsecure}, so the nonsecure bit reaches attr[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted on this cycle |
| req_iova | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| dir_base | input | 32 | Directory base of the active address space |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry value |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Access denied or address space disabled |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_attr | output | 3 | {readable, writable, nonsecure} of the final entry |

## Verification
Latency is counted from the clock edge that accepts a request. The bench's memory always accepts at once and answers one cycle later. Under those conditions:

- a disabled address space answers one cycle after acceptance;
- a walk that stops at the directory level answers after three cycles;
- a full two-level walk answers after five cycles.

The bench samples on the falling edge following each rising edge. It counts how many of those samples pass before the result pulse appears, and compares that count with the expected latency in the vector. A separate stall test holds the memory's ready low and checks that the latency grows by exactly the stall length. The same test checks that the request address stays frozen throughout the stall.

// File: rtl/walk_pkg.sv
package walk_pkg;
  parameter int ADDR_W     = 32;
  parameter int ENTRY_W    = 32;
  parameter int FRAME_W    = 20;
  parameter int PAGE_SHIFT = 12;
  parameter int DIR_IDX_W  = 10;
  parameter int TBL_IDX_W  = 10;
  parameter int SLOT_SHIFT = 2;
  parameter int NEXT_BIT   = 28;
  parameter int ATTR_W     = 3;

  localparam int SECT_SHIFT = PAGE_SHIFT + TBL_IDX_W;
  localparam int ATTR_LSB   = ENTRY_W - ATTR_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECT_SHIFT) - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_TBL, ST_RESP} walk_state_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } walk_attr_t;

  function automatic logic [ADDR_W-1:0] frame_to_addr(input logic [FRAME_W-1:0] f);
    return ADDR_W'(f) << PAGE_SHIFT;
  endfunction

  function automatic logic [ADDR_W-1:0] dir_slot_addr(input logic [FRAME_W-1:0] f,
                                                      input logic [ADDR_W-1:0] va);
    return frame_to_addr(f) + (ADDR_W'(va[ADDR_W-1 -: DIR_IDX_W]) << SLOT_SHIFT);
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_slot_addr(input logic [FRAME_W-1:0] f,
                                                      input logic [ADDR_W-1:0] va);
    return frame_to_addr(f) + (ADDR_W'(va[SECT_SHIFT-1 -: TBL_IDX_W]) << SLOT_SHIFT);
  endfunction

  function automatic logic [ADDR_W-1:0] section_pa(input logic [FRAME_W-1:0] f,
                                                   input logic [ADDR_W-1:0] va);
    return (frame_to_addr(f) & ~SECT_MASK) | (va & SECT_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] page_pa(input logic [FRAME_W-1:0] f,
                                                input logic [ADDR_W-1:0] va);
    return frame_to_addr(f) | (va & PAGE_MASK);
  endfunction

  function automatic logic access_denied(input walk_attr_t a, input logic is_write);
    return is_write ? !a.wr : !a.rd;
  endfunction
endpackage

// File: rtl/walk_entry_decode.sv
module walk_entry_decode
  import walk_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  output walk_attr_t         attr,
  output logic               next_lvl,
  output logic [FRAME_W-1:0] frame,
  output logic               deny
);
  always_comb begin
    attr     = walk_attr_t'(entry[ENTRY_W-1 -: ATTR_W]);
    next_lvl = entry[NEXT_BIT];
    frame    = entry[FRAME_W-1:0];
    deny     = access_denied(attr, is_write);
  end
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
  import walk_pkg::*;
(
  input  walk_state_e        state,
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [ADDR_W-1:0]  va,
  output logic [ADDR_W-1:0]  slot_addr
);
  always_comb begin
    if (state == ST_TBL) slot_addr = tbl_slot_addr(tbl_frame, va);
    else                 slot_addr = dir_slot_addr(dir_frame, va);
  end
endmodule

// File: rtl/iova_table_walker.sv
module iova_table_walker
  import walk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_iova,
  input  logic                req_write,
  input  logic [ENTRY_W-1:0]  dir_base,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [ENTRY_W-1:0]  mem_rsp_data,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [ADDR_W-1:0]   rsp_pa,
  output logic [ATTR_W-1:0]   rsp_attr
);
  walk_state_e        state_q;
  logic               sent_q;
  logic [ADDR_W-1:0]  va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic               fault_q;
  logic [ADDR_W-1:0]  pa_q;
  walk_attr_t         attr_q;

  // named events for the assertions
  logic       accept;
  logic       base_off;
  logic       walking;
  logic       mem_fire;
  logic       rsp_take;
  walk_attr_t ent_attr;
  logic       ent_next;
  logic [FRAME_W-1:0] ent_frame;
  logic       ent_deny;

  assign base_off  = (dir_base == '0);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign walking   = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign mem_req_valid = walking && !sent_q;
  assign mem_fire  = mem_req_valid && mem_req_ready;
  assign rsp_take  = walking && sent_q && mem_rsp_valid;

  walk_entry_decode u_decode (
    .entry    (mem_rsp_data),
    .is_write (wr_q),
    .attr     (ent_attr),
    .next_lvl (ent_next),
    .frame    (ent_frame),
    .deny     (ent_deny)
  );

  walk_addr_gen u_addr (
    .state     (state_q),
    .dir_frame (dir_frame_q),
    .tbl_frame (tbl_frame_q),
    .va        (va_q),
    .slot_addr (mem_req_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sent_q      <= 1'b0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      dir_frame_q <= '0;
      tbl_frame_q <= '0;
      fault_q     <= 1'b0;
      pa_q        <= '0;
      attr_q      <= '0;
    end else begin
      if (mem_fire) sent_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          va_q        <= req_iova;
          wr_q        <= req_write;
          dir_frame_q <= dir_base[FRAME_W-1:0];
          sent_q      <= 1'b0;
          if (base_off) begin
            state_q <= ST_RESP;
            fault_q <= 1'b1;
            pa_q    <= '0;
            attr_q  <= '0;
          end else begin
            state_q <= ST_DIR;
          end
        end
        ST_DIR, ST_TBL: if (rsp_take) begin
          sent_q <= 1'b0;
          attr_q <= ent_attr;
          if (ent_deny) begin
            state_q <= ST_RESP;
            fault_q <= 1'b1;
            pa_q    <= '0;
          end else if (state_q == ST_DIR && ent_next) begin
            state_q     <= ST_TBL;
            tbl_frame_q <= ent_frame;
          end else begin
            state_q <= ST_RESP;
            fault_q <= 1'b0;
            pa_q    <= (state_q == ST_DIR) ? section_pa(ent_frame, va_q)
                                           : page_pa(ent_frame, va_q);
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_pa    = pa_q;
  assign rsp_attr  = attr_q;

  p_dir_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !base_off) |=> mem_req_valid &&
      mem_req_addr == ({$past(dir_base[FRAME_W-1:0]), 12'b0} +
                       {20'b0, $past(req_iova[31:22]), 2'b0}));
  p_next_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && state_q == ST_DIR && ent_next && !ent_deny) |=> mem_req_valid && !rsp_valid);
  p_deny_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && ent_deny) |=> rsp_valid && rsp_fault);
  p_fault_pa_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_pa == '0);
  p_base_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && base_off) |=> rsp_valid && rsp_fault && !mem_req_valid);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  p_single_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |=> !mem_req_valid);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/test_iova_table_walker.sv
module test_iova_table_walker;
  localparam int PERIOD = 10;
  localparam logic [31:0] B1 = 32'hE000_0100;
  localparam logic [31:0] B2 = 32'h0000_0400;

  typedef struct packed {
    logic [31:0] iova;
    logic        wr;
    logic [31:0] base;
    logic        fault;
    logic [31:0] pa;
    logic [2:0]  attr;
    logic [7:0]  lat;
    logic [3:0]  reads;
    logic [31:0] a0;
    logic [31:0] a1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_3ABC, 1'b0, B1, 1'b0, 32'h1234_5ABC, 3'b111, 8'd5, 4'd2, 32'h0010_0004, 32'h0020_000C},
    '{32'h0040_4010, 1'b0, B1, 1'b0, 32'h5432_1010, 3'b100, 8'd5, 4'd2, 32'h0010_0004, 32'h0020_0010},
    '{32'h0040_4010, 1'b1, B1, 1'b1, 32'h0,         3'b100, 8'd5, 4'd2, 32'h0010_0004, 32'h0020_0010},
    '{32'h0081_2345, 1'b0, B1, 1'b0, 32'hABC1_2345, 3'b110, 8'd3, 4'd1, 32'h0010_0008, 32'h0},
    '{32'h00C0_5008, 1'b0, B1, 1'b1, 32'h0,         3'b010, 8'd3, 4'd1, 32'h0010_000C, 32'h0},
    '{32'h00C0_5008, 1'b1, B1, 1'b0, 32'h00C0_5008, 3'b111, 8'd5, 4'd2, 32'h0010_000C, 32'h0030_0014},
    '{32'hFFC1_2345, 1'b0, B1, 1'b0, 32'hFFC1_2345, 3'b111, 8'd3, 4'd1, 32'h0010_0FFC, 32'h0},
    '{32'h0040_3ABC, 1'b0, 32'h0, 1'b1, 32'h0,      3'b000, 8'd1, 4'd0, 32'h0,         32'h0},
    '{32'h0000_0123, 1'b0, B2, 1'b1, 32'h0,         3'b000, 8'd3, 4'd1, 32'h0040_0000, 32'h0}
  };
  localparam string VTAG [NV] = '{"R2", "R10", "R5", "R3", "R4", "R7", "R7", "R6", "R1"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_iova = '0;
  logic        req_write = 1'b0;
  logic [31:0] dir_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_attr;

  int n_checks = 0;
  int n_fail   = 0;

  always #(PERIOD/2) clk = ~clk;

  iova_table_walker i_iova_table_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_iova, .req_write, .dir_base,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .rsp_valid, .rsp_fault, .rsp_pa, .rsp_attr
  );

  // memory model: accepts when ready, answers one cycle later
  logic [31:0] mem_tab [logic [31:0]];
  int          rd_total = 0;
  logic [31:0] addr_last = '0;
  logic [31:0] addr_prev = '0;

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    if (mem_tab.exists(a)) return mem_tab[a];
    if (a >= 32'h0010_0000 && a < 32'h0010_1000)
      return ((a - 32'h0010_0000) >> 2 << 10) | 32'hE000_0000;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= mem_read(mem_req_addr);
      rd_total     <= rd_total + 1;
      addr_prev    <= addr_last;
      addr_last    <= mem_req_addr;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] va, input logic wr, input logic [31:0] base,
                         output logic f, output logic [31:0] pa, output logic [2:0] at,
                         output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_iova = va; req_write = wr; dir_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    f = rsp_fault; pa = rsp_pa; at = rsp_attr;
    @(negedge clk);
    check("R10", "valid pulse ends", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic        f;
    logic [31:0] pa;
    logic [2:0]  at;
    int          lat;
    int          r0;

    mem_tab[32'h0010_0004] = 32'hF000_0200;
    mem_tab[32'h0020_000C] = 32'hE001_2345;
    mem_tab[32'h0020_0010] = 32'h8005_4321;
    mem_tab[32'h0010_0008] = 32'hC00A_BC00;
    mem_tab[32'h0010_000C] = 32'h5000_0300;
    mem_tab[32'h0030_0014] = (32'h00C0_5008 >> 12) | 32'hE000_0000;

    repeat (3) @(negedge clk);
    check("R9", "req_ready", {31'b0, req_ready}, 32'h1);
    check("R9", "mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
    check("R9", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      r0 = rd_total;
      run_req(VECS[i].iova, VECS[i].wr, VECS[i].base, f, pa, at, lat);
      check(VTAG[i], "fault", {31'b0, f}, {31'b0, VECS[i].fault});
      check(VTAG[i], "pa", pa, VECS[i].pa);
      check(VTAG[i], "attr", {29'b0, at}, {29'b0, VECS[i].attr});
      check(VTAG[i], "latency", lat, {24'b0, VECS[i].lat});
      check(VTAG[i], "reads", rd_total - r0, {28'b0, VECS[i].reads});
      if (VECS[i].reads == 4'd2) begin
        check("R1", "dir slot addr", addr_prev, VECS[i].a0);
        check("R2", "table slot addr", addr_last, VECS[i].a1);
      end else if (VECS[i].reads == 4'd1) begin
        check("R1", "dir slot addr", addr_last, VECS[i].a0);
      end
    end

    // R8: stalled memory; address frozen, new requests refused while busy
    mem_req_ready = 1'b0;
    r0 = rd_total;
    @(negedge clk);
    req_valid = 1'b1; req_iova = 32'h0081_2345; req_write = 1'b0; dir_base = B1;
    @(negedge clk);
    req_iova = 32'hFFC1_2345;
    for (int k = 0; k < 4; k++) begin
      check("R8", "req held", {31'b0, mem_req_valid}, 32'h1);
      check("R8", "addr stable", mem_req_addr, 32'h0010_0008);
      check("R8", "busy not ready", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    mem_req_ready = 1'b1;
    lat = 5;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check("R8", "stall latency", lat, 32'd7);
    check("R8", "stall pa", rsp_pa, 32'hABC1_2345);
    @(negedge clk);
    check("R8", "one read only", rd_total - r0, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule